// File: doc/BRIEF.md
# I2C Tuning Register Receiver

A write-only I2C slave that loads the tuning word and control settings of a frequency synthesizer. The bus lines arrive as plain inputs sampled by the core clock. A two-stage synchronizer and edge detector extract START, STOP and the SCL edges. A bit engine then shifts in bytes and drives the acknowledge through an open-drain pull output.

After the address byte, the data bytes are handled in pairs. The top bit of the first byte of each pair selects its meaning. A 0 marks a frequency pair, which writes the 15-bit divider word. A 1 marks a control pair, which writes the control bits T14..T6 and the three band bits. A pair is committed only after its second byte has been acknowledged. Every START, including a repeated one, produces a one-cycle transfer pulse for the divider latch logic.

Top module: `tune_rx_top`

## Requirements
- R1: The block acknowledges an address byte equal to {5'b11000, addr_sel_i[1:0], 1'b0} by asserting sda_pull_o (pull SDA low) during the ninth SCL clock.
- R2: Any other address byte, including one whose R/W bit is 1, gets no acknowledge. The rest of that transfer is ignored until the next START: no acknowledge and no latch change.
- R3: A data pair whose first byte has bit 7 = 0 is a frequency pair. Bits 6:0 of the first byte give div_word_o[14:8] and the second byte gives div_word_o[7:0].
- R4: A data pair whose first byte has bit 7 = 1 is a control pair. Bits 6:0 of the first byte give ctrl_o[8:2] (T14..T8). From the second byte, bit 7 gives ctrl_o[1] (T7), bit 6 gives ctrl_o[0] (T6), bit 5 gives band_o[2] (B5), bit 3 gives band_o[1] (B3) and bit 0 gives band_o[0] (B1). Bits 4, 2 and 1 are ignored.
- R5: The first four data bytes of an addressed transfer are acknowledged. With four data bytes, both pairs are written, in either order.
- R6: With exactly three data bytes, the third byte changes no output.
- R7: The fifth and later data bytes get no acknowledge and change no output.
- R8: A transfer that ends, or restarts, after the first byte of a pair leaves all latches unchanged. A pending first byte is never combined with a byte of a later transfer.
- R9: Each START condition, including a repeated START, produces exactly one single-cycle pulse on xfer_pulse_o.
- R10: After reset, div_word_o = 15'h0100, ctrl_o = 0, band_o = 0 and sda_pull_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired value) |
| addr_sel_i | input | 2 | Selects address bits 2:1 |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| div_word_o | output | 15 | Programmable divider word N14..N0 |
| ctrl_o | output | 9 | Control bits T14..T6, MSB first |
| band_o | output | 3 | Band bits {B5, B3, B1} |
| xfer_pulse_o | output | 1 | One-cycle pulse per START condition |

## Verification
The bench sends transfers with 0 to 6 data bytes. This catches two count errors: a design that committed an odd trailing byte would corrupt a latch, and one that counted acknowledges wrongly would answer a fifth byte. Repeated STARTs that follow a half-sent pair expose a pending byte that leaks into the next transfer. The same traffic shows a transfer pulse that is missing on a restart or lasts more than one cycle. Wrong addresses and read-direction addresses check that a rejected transfer stays silent to its end. Don't-care bits are set in band bytes, so a shifted field mapping shows up on the outputs.

// File: rtl/tune_rx_pkg.sv
package tune_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 15;
  localparam int CTRL_W = 9;
  localparam int BAND_W = 3;
  localparam logic [4:0]        ADDR_HI   = 5'b11000;
  localparam logic [DIV_W-1:0]  DIV_RESET = 15'h0100;

  typedef enum logic [1:0] {LK_IDLE, LK_RX, LK_SKIP} link_st_e;

  function automatic logic [BAND_W-1:0] band_pick(input logic [BYTE_W-1:0] b);
    return {b[5], b[3], b[0]};
  endfunction
endpackage

// File: rtl/tune_rx_sync.sv
module tune_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, synced;
  logic       scl_p, sda_p;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= synced[0];
      sda_p <= synced[1];
    end
  end

  assign scl_o      = synced[0];
  assign sda_o      = synced[1];
  assign scl_rise_o = synced[0] & ~scl_p;
  assign scl_fall_o = ~synced[0] & scl_p;
  assign start_o    = synced[0] & scl_p & sda_p & ~synced[1];
  assign stop_o     = synced[0] & scl_p & ~sda_p & synced[1];
endmodule

// File: rtl/tune_rx_link.sv
module tune_rx_link
  import tune_rx_pkg::*;
#(
  parameter int MAX_DATA = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        addr_sel_i,
  output logic              pull_o,
  output logic              stb_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              second_o,
  output logic              start_pulse_o
);
  localparam int CNT_W = $clog2(MAX_DATA + 1);

  link_st_e          st;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              is_addr;
  logic [CNT_W-1:0]  dcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st            <= LK_IDLE;
      bit_cnt       <= '0;
      shreg         <= '0;
      is_addr       <= 1'b0;
      dcnt          <= '0;
      pull_o        <= 1'b0;
      stb_o         <= 1'b0;
      byte_o        <= '0;
      second_o      <= 1'b0;
      start_pulse_o <= 1'b0;
    end else begin
      stb_o         <= 1'b0;
      start_pulse_o <= start_i;
      if (start_i) begin
        st      <= LK_RX;
        bit_cnt <= '0;
        is_addr <= 1'b1;
        dcnt    <= '0;
        pull_o  <= 1'b0;
      end else if (stop_i) begin
        st     <= LK_IDLE;
        pull_o <= 1'b0;
      end else if (st == LK_RX) begin
        if (scl_rise_i && bit_cnt < 4'd8) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_i};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall_i && bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
          if (is_addr) begin
            if (shreg == {ADDR_HI, addr_sel_i, 1'b0}) pull_o <= 1'b1;
            else                                      st     <= LK_SKIP;
          end else if (dcnt < CNT_W'(MAX_DATA)) begin
            pull_o <= 1'b1;
          end
        end else if (scl_fall_i && bit_cnt == 4'd9) begin
          bit_cnt <= '0;
          pull_o  <= 1'b0;
          if (is_addr) begin
            is_addr <= 1'b0;
          end else if (pull_o) begin
            stb_o    <= 1'b1;
            byte_o   <= shreg;
            second_o <= dcnt[0];
            dcnt     <= dcnt + 1'b1;
          end
        end
      end
    end
  end

  AST_SKIP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == LK_SKIP |-> !pull_o); // R2
  AST_ACK_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_o) |-> !scl_i); // R1
  AST_STB_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> $past(pull_o)); // R7
  AST_START_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse_o |=> !start_pulse_o); // R9
  AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= 4'd9); // R5
endmodule

// File: rtl/tune_rx_regs.sv
module tune_rx_regs
  import tune_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              second_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [BAND_W-1:0] band_o
);
  logic [BYTE_W-1:0] hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold   <= '0;
      div_o  <= DIV_RESET;
      ctrl_o <= '0;
      band_o <= '0;
    end else if (stb_i) begin
      if (!second_i) begin
        hold <= byte_i;
      end else if (!hold[BYTE_W-1]) begin
        div_o <= {hold[BYTE_W-2:0], byte_i};
      end else begin
        ctrl_o <= {hold[BYTE_W-2:0], byte_i[7], byte_i[6]};
        band_o <= band_pick(byte_i);
      end
    end
  end

  AST_DIV_ON_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> $past(stb_i && second_i)); // R8
  AST_CTRL_ON_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({ctrl_o, band_o}) |-> $past(stb_i && second_i)); // R6
endmodule

// File: rtl/tune_rx_top.sv
module tune_rx_top
  import tune_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_DATA    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_sel_i,
  output logic              sda_pull_o,
  output logic [DIV_W-1:0]  div_word_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [BAND_W-1:0] band_o,
  output logic              xfer_pulse_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic stb, second;
  logic [BYTE_W-1:0] rx_byte;

  tune_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  tune_rx_link #(.MAX_DATA(MAX_DATA)) u_link (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev), .addr_sel_i,
    .pull_o(sda_pull_o), .stb_o(stb), .byte_o(rx_byte), .second_o(second),
    .start_pulse_o(xfer_pulse_o)
  );

  tune_rx_regs u_regs (
    .clk_i, .rst_ni, .stb_i(stb), .byte_i(rx_byte), .second_i(second),
    .div_o(div_word_o), .ctrl_o, .band_o
  );

  AST_RESET_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_pulse_o |-> !sda_pull_o); // R10
endmodule

// File: tb/sim_tune_rx_top.sv
module sim_tune_rx_top;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'd0;
  logic sda_pull, xfer;
  logic [14:0] div_w;
  logic [8:0]  ctrl;
  logic [2:0]  band;
  wire  sda_bus = sda_m & ~sda_pull;

  int n_chk = 0, n_bad = 0, pulse_cnt = 0, start_cnt = 0;
  bit done = 1'b0;
  logic [7:0] msg [8];
  logic [14:0] e_div = 15'h0100;
  logic [8:0]  e_ctrl = '0;
  logic [2:0]  e_band = '0;

  always #2.5 clk = ~clk;

  tune_rx_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(sel), .sda_pull_o(sda_pull), .div_word_o(div_w),
    .ctrl_o(ctrl), .band_o(band), .xfer_pulse_o(xfer)
  );

  always @(negedge clk) if (xfer) pulse_cnt++;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    start_cnt++;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(Q/2);
    acked = !sda_bus;
    wq(Q - Q/2); scl_m = 1'b0; wq();
  endtask

  task automatic commit(input logic [7:0] hi, input logic [7:0] lo);
    if (!hi[7]) e_div = {hi[6:0], lo};
    else begin
      e_ctrl = {hi[6:0], lo[7], lo[6]};
      e_band = {lo[5], lo[3], lo[0]};
    end
  endtask

  // msg[0] is the address, msg[1..n] data
  task automatic run_msg(int n, bit do_stop, string tag);
    bit ack, match;
    match = (msg[0] == {5'b11000, sel, 1'b0});
    bus_start();
    for (int i = 0; i <= n; i++) begin
      send_byte(msg[i], ack);
      if (i == 0) check(match ? "R1 addr ack" : "R2 addr nack", ack, match);
      else if (i > 4) check("R7 no ack past fourth", ack, 0);
      else check(match ? "R5 data ack" : "R2 silent", ack, match);
    end
    if (match) begin
      if (n >= 2) commit(msg[1], msg[2]);
      if (n >= 4) commit(msg[3], msg[4]);
    end
    if (do_stop) bus_stop();
    wq(4);
    check({tag, " div"}, div_w, e_div);
    check({tag, " ctrl"}, ctrl, e_ctrl);
    check({tag, " band"}, band, e_band);
    check("R9 start pulses", pulse_cnt, start_cnt);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    wq(5); rst_n = 1'b1; wq(3);
    // R10
    check("R10 div", div_w, 15'h0100);
    check("R10 ctrl", ctrl, 0);
    check("R10 band", band, 0);
    check("R10 pull", sda_pull, 0);

    sel = 2'd0; msg[0] = 8'hC0; msg[1] = 8'h35; msg[2] = 8'hA7;
    run_msg(2, 1, "R3");
    sel = 2'd3; msg[0] = 8'hC6; msg[1] = 8'hD5; msg[2] = 8'h56;
    run_msg(2, 1, "R4");
    msg[1] = 8'hAA; msg[2] = 8'hBF; msg[3] = 8'h12; msg[4] = 8'h34;
    run_msg(4, 1, "R5");
    msg[1] = 8'h7F; msg[2] = 8'hFF; msg[3] = 8'h80; msg[4] = 8'h00;
    run_msg(4, 1, "R5");
    msg[1] = 8'h01; msg[2] = 8'h02; msg[3] = 8'hFF;
    run_msg(3, 1, "R6");
    msg[1] = 8'h03; msg[2] = 8'h04; msg[3] = 8'hC1; msg[4] = 8'h29;
    msg[5] = 8'h05; msg[6] = 8'h06;
    run_msg(6, 1, "R7");
    sel = 2'd1; msg[0] = 8'hC6; msg[1] = 8'h11; msg[2] = 8'h22;
    run_msg(2, 1, "R2");
    msg[0] = 8'hC3;
    run_msg(2, 1, "R2");
    msg[0] = 8'hC2; msg[1] = 8'h2A;
    run_msg(1, 0, "R8");
    msg[1] = 8'h99;
    run_msg(1, 0, "R8");
    msg[1] = 8'h66;
    run_msg(1, 1, "R8");

    for (int k = 0; k < 40; k++) begin
      int n;
      sel = 2'($urandom_range(0, 3));
      msg[0] = ($urandom_range(0, 9) < 7) ? {5'b11000, sel, 1'b0} : 8'($urandom);
      for (int j = 1; j < 8; j++) msg[j] = 8'($urandom);
      n = $urandom_range(0, 6);
      run_msg(n, $urandom_range(0, 3) != 0, "R5 random");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule